// File: doc/BRIEF.md
# Bus Cycle Classifier for an 8-bit CPU Bus

This block watches the bus of an 8-bit microprocessor through a free-running monitor clock. On every monitor clock it takes one sample of the five active-low control strobes, the 8-bit data bus and the 16-bit address bus. It decides which kind of bus cycle that sample belongs to: idle, memory read, memory write, I/O read, I/O write, opcode fetch or interrupt acknowledge.

It reports cycle boundaries as one-cycle pulses. A pulse marks where a cycle begins. Another pulse marks where a cycle ends, and it carries the ended cycle's type, a coarse data class, the address latched when the cycle began and the final data byte seen while the cycle ran. A hop from one active cycle type straight to a different one raises a warning pulse, and the capture for that cycle is thrown away.

The strobes and both buses pass through a two-stage synchronizer before classification. Two configuration inputs say whether the memory-request and I/O-request strobes are wired at all. An unwired strobe takes a fixed default level.

Top module: `cpuBusCycleTap`

## Requirements
- R1: With the memory request taken as asserted, the sample is classified as follows. If read is low, it is an opcode fetch when M1 is low and a memory read otherwise. If read is high and write is low, it is a memory write. Read takes precedence over write.
- R2: With the memory request not asserted and the I/O request asserted, the sample is classified as follows. M1 low gives interrupt acknowledge. Otherwise read low gives an I/O read, and read high with write low gives an I/O write. Memory request takes precedence over I/O request.
- R3: When `mreqPresent` is 0, the memory-request strobe is taken as asserted whatever its pin level. When `iorqPresent` is 0, the I/O-request strobe is taken as deasserted.
- R4: A sample classified active after an idle sample gives `beginPulse` for one cycle. The address bus value of that sample is the address reported at the end of the cycle, and later address changes within the cycle are ignored.
- R5: The data byte reported at cycle end is the data bus value of the last active sample of the cycle.
- R6: The first idle sample after an active cycle gives `endValid` for one cycle. It carries `endType` (1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 opcode fetch, 6 interrupt acknowledge) and `endKind` (0 for fetch or memory read, 1 for memory write, 2 for I/O read or interrupt acknowledge, 3 for I/O write).
- R7: An active sample whose type differs from the preceding active sample gives `warnPulse` for one cycle. The end of that run of active samples gives no `endValid`.
- R8: A sample presented before rising edge n affects the outputs after rising edge n+2.
- R9: A synchronous reset clears every pulse and every output field to zero and treats the bus as idle.
- R10: `endType`, `endKind`, `endAddr` and `endData` keep their values until the next `endValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous reset, active high |
| mreqPresent | input | 1 | 1 when the memory-request strobe is wired |
| iorqPresent | input | 1 | 1 when the I/O-request strobe is wired |
| m1N | input | 1 | First-machine-cycle strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| mreqN | input | 1 | Memory-request strobe, active low |
| iorqN | input | 1 | I/O-request strobe, active low |
| dataBus | input | 8 | Sampled data bus |
| addrBus | input | 16 | Sampled address bus |
| beginPulse | output | 1 | One-cycle pulse on idle-to-active |
| endValid | output | 1 | One-cycle pulse on a reported cycle end |
| endType | output | 3 | Type of the ended cycle |
| endKind | output | 2 | Data class of the ended cycle |
| endAddr | output | 16 | Address latched at cycle begin |
| endData | output | 8 | Last data byte of the cycle |
| warnPulse | output | 1 | One-cycle pulse on an illegal type hop |

## Verification
A wrong previous-type register shows as a missing or extra `beginPulse` or `warnPulse` three edges after the sample that exposes it. A stuck capture-valid flag shows at the next cycle end, either as an `endValid` that should have been dropped or as a lost one. A bad address or data hold register shows only when `endValid` fires, so every stimulus cycle is closed with an idle sample to bring it out. The bench follows each sample through a model and compares every output on every clock, so a divergence is caught within three clocks of the sample that causes it.

// File: rtl/busTapPkg.sv
package busTapPkg;

  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_MEMRD  = 3'd1,
    CYC_MEMWR  = 3'd2,
    CYC_IORD   = 3'd3,
    CYC_IOWR   = 3'd4,
    CYC_FETCH  = 3'd5,
    CYC_INTACK = 3'd6
  } cycType_t;

  // strobes from control to datapath
  typedef struct packed {
    logic beginEv;
    logic sampleEv;
    logic finishEv;
    logic illegalEv;
  } tapCtrl_t;

  function automatic logic [1:0] kindOf(cycType_t t);
    case (t)
      CYC_MEMWR:             kindOf = 2'd1;
      CYC_IORD, CYC_INTACK:  kindOf = 2'd2;
      CYC_IOWR:              kindOf = 2'd3;
      default:               kindOf = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/busTapCtrl.sv
module busTapCtrl
  import busTapPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     mreqPresent,
  input  logic     iorqPresent,
  input  logic [4:0] strobeN,   // {m1, rd, wr, mreq, iorq}
  output tapCtrl_t ctrl,
  output cycType_t prevType
);

  localparam int M1B = 4;
  localparam int RDB = 3;
  localparam int WRB = 2;
  localparam int MQB = 1;
  localparam int IOB = 0;

  logic [4:0] syncQ [SYNC_STAGES];

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk)
          if (rst) syncQ[g] <= '1;
          else     syncQ[g] <= strobeN;
      end else begin : gNext
        always_ff @(posedge clk)
          if (rst) syncQ[g] <= '1;
          else     syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  logic [4:0] s;
  logic mreqOn, iorqOn, captureValid;
  cycType_t curType;

  assign s = syncQ[SYNC_STAGES-1];

  always_comb begin
    mreqOn  = mreqPresent ? ~s[MQB] : 1'b1;
    iorqOn  = iorqPresent ? ~s[IOB] : 1'b0;
    curType = CYC_IDLE;
    if (mreqOn) begin
      if (!s[RDB])      curType = s[M1B] ? CYC_MEMRD : CYC_FETCH;
      else if (!s[WRB]) curType = CYC_MEMWR;
    end else if (iorqOn) begin
      if (!s[M1B])      curType = CYC_INTACK;
      else if (!s[RDB]) curType = CYC_IORD;
      else if (!s[WRB]) curType = CYC_IOWR;
    end
  end

  always_comb begin
    ctrl.beginEv   = (prevType == CYC_IDLE) && (curType != CYC_IDLE);
    ctrl.sampleEv  = (curType != CYC_IDLE);
    ctrl.finishEv  = (curType == CYC_IDLE) && (prevType != CYC_IDLE) && captureValid;
    ctrl.illegalEv = (curType != CYC_IDLE) && (prevType != CYC_IDLE) && (curType != prevType);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevType     <= CYC_IDLE;
      captureValid <= 1'b0;
    end else begin
      prevType <= curType;
      if (ctrl.illegalEv)    captureValid <= 1'b0;
      else if (ctrl.beginEv) captureValid <= 1'b1;
    end
  end

  // R6
  finish_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.finishEv |=> (prevType == CYC_IDLE));

  // R7
  illegal_drops_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.illegalEv |=> !ctrl.finishEv);

endmodule

// File: rtl/busTapData.sv
module busTapData
  import busTapPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataBus,
  input  logic [ADDR_W-1:0] addrBus,
  input  tapCtrl_t          ctrl,
  input  cycType_t          prevType,
  output logic              beginPulse,
  output logic              endValid,
  output logic [2:0]        endType,
  output logic [1:0]        endKind,
  output logic [ADDR_W-1:0] endAddr,
  output logic [DATA_W-1:0] endData,
  output logic              warnPulse
);

  localparam int BUS_W = DATA_W + ADDR_W;

  logic [BUS_W-1:0] busQ [SYNC_STAGES];

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk)
          if (rst) busQ[g] <= '0;
          else     busQ[g] <= {addrBus, dataBus};
      end else begin : gNext
        always_ff @(posedge clk)
          if (rst) busQ[g] <= '0;
          else     busQ[g] <= busQ[g-1];
      end
    end
  endgenerate

  logic [DATA_W-1:0] dataNow, dataHold;
  logic [ADDR_W-1:0] addrNow, addrHold;

  assign {addrNow, dataNow} = busQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dataHold   <= '0;
      addrHold   <= '0;
      beginPulse <= 1'b0;
      endValid   <= 1'b0;
      warnPulse  <= 1'b0;
      endType    <= '0;
      endKind    <= '0;
      endAddr    <= '0;
      endData    <= '0;
    end else begin
      beginPulse <= ctrl.beginEv;
      endValid   <= ctrl.finishEv;
      warnPulse  <= ctrl.illegalEv;
      if (ctrl.beginEv)  addrHold <= addrNow;
      if (ctrl.sampleEv) dataHold <= dataNow;
      if (ctrl.finishEv) begin
        endType <= prevType;
        endKind <= kindOf(prevType);
        endAddr <= addrHold;
        endData <= dataHold;
      end
    end
  end

  // R4
  begin_single_chk: assert property (@(posedge clk) disable iff (rst)
    beginPulse |=> !beginPulse);

  // R6
  end_single_chk: assert property (@(posedge clk) disable iff (rst)
    endValid |=> !endValid);

  // R6
  end_type_active_chk: assert property (@(posedge clk) disable iff (rst)
    endValid |-> (endType != 3'd0));

  // R7
  warn_no_end_chk: assert property (@(posedge clk) disable iff (rst)
    warnPulse |=> !endValid);

  // R10
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !endValid |-> ($stable(endAddr) && $stable(endData) && $stable(endType)));

endmodule

// File: rtl/cpuBusCycleTap.sv
module cpuBusCycleTap
  import busTapPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mreqPresent,
  input  logic              iorqPresent,
  input  logic              m1N,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic [DATA_W-1:0] dataBus,
  input  logic [ADDR_W-1:0] addrBus,
  output logic              beginPulse,
  output logic              endValid,
  output logic [2:0]        endType,
  output logic [1:0]        endKind,
  output logic [ADDR_W-1:0] endAddr,
  output logic [DATA_W-1:0] endData,
  output logic              warnPulse
);

  tapCtrl_t ctrl;
  cycType_t prevType;

  busTapCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst(rst),
    .mreqPresent(mreqPresent), .iorqPresent(iorqPresent),
    .strobeN({m1N, rdN, wrN, mreqN, iorqN}),
    .ctrl(ctrl), .prevType(prevType)
  );

  busTapData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rst(rst),
    .dataBus(dataBus), .addrBus(addrBus),
    .ctrl(ctrl), .prevType(prevType),
    .beginPulse(beginPulse), .endValid(endValid),
    .endType(endType), .endKind(endKind),
    .endAddr(endAddr), .endData(endData),
    .warnPulse(warnPulse)
  );

endmodule

// File: tb/tb_cpuBusCycleTap.sv
module tb_cpuBusCycleTap;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mreqPresent = 1'b1, iorqPresent = 1'b1;
  logic m1N = 1, rdN = 1, wrN = 1, mreqN = 1, iorqN = 1;
  logic [7:0]  dataBus = '0;
  logic [15:0] addrBus = '0;
  logic beginPulse, endValid, warnPulse;
  logic [2:0] endType;
  logic [1:0] endKind;
  logic [15:0] endAddr;
  logic [7:0]  endData;

  cpuBusCycleTap dut (
    .clk(clk), .rst(rst), .mreqPresent(mreqPresent), .iorqPresent(iorqPresent),
    .m1N(m1N), .rdN(rdN), .wrN(wrN), .mreqN(mreqN), .iorqN(iorqN),
    .dataBus(dataBus), .addrBus(addrBus),
    .beginPulse(beginPulse), .endValid(endValid), .endType(endType),
    .endKind(endKind), .endAddr(endAddr), .endData(endData), .warnPulse(warnPulse)
  );

  always #5 clk = ~clk;

  // strobe patterns {m1, rd, wr, mreq, iorq}, active low
  localparam logic [4:0] P_IDLE = 5'b11111, P_FETCH = 5'b00101, P_MEMRD = 5'b10101,
                         P_MEMWR = 5'b11001, P_IORD = 5'b10110, P_IOWR = 5'b11010,
                         P_INTACK = 5'b01110;

  int checks = 0, fails = 0, n = 0;
  bit done = 0;
  string typeTag = "R6";

  logic        eBeg [4096], eEnd [4096], eWarn [4096];
  logic [2:0]  eType [4096];
  logic [1:0]  eKind [4096];
  logic [15:0] eAddr [4096];
  logic [7:0]  eData [4096];

  int mPrev = 0; bit mCap = 0;
  logic [15:0] mAddr = '0, lAddr = '0;
  logic [7:0]  mData = '0, lData = '0;
  logic [2:0]  lType = '0;
  logic [1:0]  lKind = '0;

  function automatic int classify(logic [4:0] p, logic mp, logic ip);
    logic mq, io;
    mq = mp ? ~p[1] : 1'b1;
    io = ip ? ~p[0] : 1'b0;
    if (mq) begin
      if (!p[3]) return p[4] ? 1 : 5;
      if (!p[2]) return 2;
      return 0;
    end
    if (io) begin
      if (!p[4]) return 6;
      if (!p[3]) return 3;
      if (!p[2]) return 4;
    end
    return 0;
  endfunction

  function automatic logic [1:0] kindExp(int t);
    case (t)
      2: return 2'd1;
      3, 6: return 2'd2;
      4: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkOut(int k);
    chk(beginPulse === eBeg[k], "R4/R8", "beginPulse", beginPulse, eBeg[k]);
    chk(endValid === eEnd[k], "R6", "endValid", endValid, eEnd[k]);
    chk(warnPulse === eWarn[k], "R7", "warnPulse", warnPulse, eWarn[k]);
    chk(endType === eType[k], typeTag, "endType", endType, eType[k]);
    chk(endKind === eKind[k], "R6", "endKind", endKind, eKind[k]);
    chk(endAddr === eAddr[k], "R4/R10", "endAddr", endAddr, eAddr[k]);
    chk(endData === eData[k], "R5/R10", "endData", endData, eData[k]);
  endtask

  // called at a negedge; applies one sample and advances one clock
  task automatic applySample(logic [4:0] p, logic [7:0] d, logic [15:0] a);
    int cur;
    bit beg, fin, ill;
    if (n >= 3) checkOut(n - 3);
    {m1N, rdN, wrN, mreqN, iorqN} = p;
    dataBus = d;
    addrBus = a;
    cur = classify(p, mreqPresent, iorqPresent);
    beg = (mPrev == 0) && (cur != 0);
    fin = (cur == 0) && (mPrev != 0) && mCap;
    ill = (cur != 0) && (mPrev != 0) && (cur != mPrev);
    if (fin) begin
      lType = 3'(mPrev); lKind = kindExp(mPrev); lAddr = mAddr; lData = mData;
    end
    if (beg) begin mAddr = a; mCap = 1; end
    if (ill) mCap = 0;
    if (cur != 0) mData = d;
    mPrev = cur;
    eBeg[n] = beg; eEnd[n] = fin; eWarn[n] = ill;
    eType[n] = lType; eKind[n] = lKind; eAddr[n] = lAddr; eData[n] = lData;
    n++;
    @(negedge clk);
  endtask

  task automatic idles(int k);
    for (int i = 0; i < k; i++) applySample(P_IDLE, 8'($urandom), 16'($urandom));
  endtask

  task automatic cyc(logic [4:0] p, int len);
    for (int i = 0; i < len; i++) applySample(p, 8'($urandom), 16'($urandom));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] pats [6];
    void'($urandom(32'd4711));
    pats = '{P_FETCH, P_MEMRD, P_MEMWR, P_IORD, P_IOWR, P_INTACK};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk({beginPulse, endValid, warnPulse} === 3'b000, "R9", "pulses", {beginPulse, endValid, warnPulse}, 0);
    chk({endType, endKind, endAddr, endData} === '0, "R9", "fields", {endType, endKind}, 0);
    rst = 0;
    idles(3);

    // R1: memory side
    typeTag = "R1";
    cyc(P_FETCH, 2); idles(1);
    cyc(P_MEMRD, 1); idles(2);
    cyc(P_MEMWR, 3); idles(1);
    cyc(5'b10001, 2); idles(1);        // read and write both low -> memory read

    // R2: I/O side and priority of memory request
    typeTag = "R2";
    cyc(P_INTACK, 2); idles(1);
    cyc(P_IORD, 2); idles(1);
    cyc(P_IOWR, 1); idles(1);
    cyc(5'b10100, 2); idles(1);        // both requests low with read -> memory read
    idles(3);

    // R3: absent strobes
    typeTag = "R3";
    mreqPresent = 0;
    cyc(5'b10111, 2); idles(1);        // mreq pin high but taken as asserted
    cyc(5'b11011, 2); idles(3);
    mreqPresent = 1; iorqPresent = 0;
    cyc(P_IORD, 2); idles(1);          // I/O request ignored -> idle
    cyc(P_MEMWR, 1); idles(3);
    iorqPresent = 1;

    // R5 and R4: data and address move within a cycle
    typeTag = "R6";
    applySample(P_MEMRD, 8'h11, 16'h1234);
    applySample(P_MEMRD, 8'h22, 16'h5678);
    applySample(P_MEMRD, 8'h33, 16'h9abc);
    idles(2);

    // R7: direct hop, then a clean cycle
    cyc(P_MEMRD, 2); cyc(P_MEMWR, 2); idles(1);
    cyc(P_FETCH, 1); cyc(P_MEMRD, 1); cyc(P_IOWR, 1); idles(1);
    cyc(P_IORD, 2); idles(2);

    // random mix
    for (int r = 0; r < 600; r++) begin
      int sel = int'($urandom % 10);
      if (sel < 3) applySample(5'($urandom), 8'($urandom), 16'($urandom));
      else begin
        cyc(pats[$urandom % 6], 1 + int'($urandom % 3));
        idles(int'($urandom % 3));
      end
      if (n > 3900) break;
    end
    idles(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule